// File: doc/BRIEF.md
# Indexed PLL Configuration Register Bank

This block holds the settings of up to eight PLL channels behind a single four-register window. Software chooses a channel by writing its index into the update register. It then writes the multiplier, fraction, divider and enable bits into two holding registers. A write to the update register with the commit bit set copies those held values into the chosen channel in one step. Until that commit, the channel's running settings stay as they were.

Each channel also carries a simple lock model. After a commit that turns on both the PLL and its lock detection, the channel's ready flag stays low for a fixed number of clock cycles and then rises. The ready flags appear on dedicated outputs and in a status register, one bit per channel. The running configuration of every channel is also driven out on flat vectors, so the clock logic that follows can use it directly.

The multiply ratio a channel describes is (MUL+1) + FRAC/2^22. The divider output runs at 1/(DIV+1) of the PLL rate.

Top module: `pllcfg_bank`

## Requirements
- R1: After reset, every channel is disabled and not ready, all of its fields are zero, the selected index is 0, and every register reads 0.
- R2: A write to the update register whose index field (bits 3:0) is N_CH or greater is ignored entirely: the selection does not change and no channel is committed.
- R3: A write to the update register with bit 8 clear and a valid index only selects a channel. Later reads of the two control registers return that channel's running settings. A read of the update register returns the selected index in bits 3:0 and always returns 0 in bit 8.
- R4: Writes to control registers 0 and 1 go to holding registers only. A channel's running settings change only at a write to the update register that has bit 8 set and carries that channel's index, and that write also selects the channel.
- R5: Register map (word address): 0 is control 0, 1 is control 1, 2 is update, 3 is status. Control 1 holds MUL in bits 31:24 and FRAC in bits 21:0. Control 0 holds DIV in bits 7:0, PLL enable in bit 28, lock enable in bit 29 and divider enable in bit 31. All other bits are dropped on write and read as 0.
- R6: Bit i of the status register, and bit i of the ready output, is the ready flag of channel i.
- R7: A commit that leaves a channel's PLL enable clear drops that channel's ready flag at the same clock edge as the commit.
- R8: A commit that sets both the PLL enable and the lock enable restarts the lock count when MUL or FRAC changes, or when the channel is neither ready nor already counting. Ready then rises exactly LOCK_CYCLES clock edges after the commit edge.
- R9: A commit that keeps MUL and FRAC unchanged does not drop ready on a channel that is already ready, and does not restart a count already in progress.
- R10: A channel whose running lock enable is clear never reports ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ready | output | N_CH | Per-channel ready flag |
| act_mul | output | N_CH*8 | Running MUL of each channel, channel i at [8i+7:8i] |
| act_frac | output | N_CH*22 | Running FRAC of each channel |
| act_div | output | N_CH*8 | Running DIV of each channel |
| pll_on | output | N_CH | Running PLL enable of each channel |
| div_on | output | N_CH | Running divider enable of each channel |

## Verification
The cases hardest to reach from the ports are the re-commits. One is a commit that lands while a lock count is still running. Another is a commit with unchanged MUL and FRAC on a channel that has already locked. Both only mean something at particular cycle offsets from an earlier commit. The stimulus therefore issues the same commit twice, once after the count has ended and once partway through a count. It also changes only the fraction between commits. A behavioural model in the bench keeps a per-channel countdown and compares the ready vector and every running field on each cycle, so an early, late or spurious ready edge shows up in the exact cycle it happens.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
   localparam int MUL_W    = 8;
   localparam int FRAC_W   = 22;
   localparam int DIV_W    = 8;
   localparam int IDX_FW   = 4;
   localparam int MUL_LSB  = 24;
   localparam int PLLEN_B  = 28;
   localparam int LOCKEN_B = 29;
   localparam int DIVEN_B  = 31;
   localparam int GO_B     = 8;

   typedef enum logic [1:0] {
      REG_CTL0 = 2'd0,
      REG_CTL1 = 2'd1,
      REG_UPDT = 2'd2,
      REG_STAT = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [MUL_W-1:0]  mul;
      logic [FRAC_W-1:0] frac;
      logic [DIV_W-1:0]  div;
      logic              pll_en;
      logic              lock_en;
      logic              div_en;
   } pll_cfg_t;
endpackage

// File: rtl/pllcfg_stage.sv
module pllcfg_stage
   import pllcfg_pkg::*;
#(
   parameter int N_CH  = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [31:0]      wdata,
   output pll_cfg_t         staged,
   output logic [SEL_W-1:0] sel_q,
   output logic             commit,
   output logic [SEL_W-1:0] commit_idx
);
   logic idx_ok;
   logic updt_wr;

   assign updt_wr    = wr_en && (addr == REG_UPDT);
   assign idx_ok     = int'(wdata[IDX_FW-1:0]) < N_CH;
   assign commit     = updt_wr && idx_ok && wdata[GO_B];
   assign commit_idx = wdata[SEL_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged <= '0;
         sel_q  <= '0;
      end else if (wr_en) begin
         case (addr)
            REG_CTL0: begin
               staged.div     <= wdata[DIV_W-1:0];
               staged.pll_en  <= wdata[PLLEN_B];
               staged.lock_en <= wdata[LOCKEN_B];
               staged.div_en  <= wdata[DIVEN_B];
            end
            REG_CTL1: begin
               staged.mul  <= wdata[MUL_LSB +: MUL_W];
               staged.frac <= wdata[FRAC_W-1:0];
            end
            REG_UPDT: if (idx_ok) sel_q <= wdata[SEL_W-1:0];
            default: ;
         endcase
      end
   end

   AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (updt_wr && !idx_ok) |=> $stable(sel_q)) else $error("bad index moved select"); // R2
endmodule

// File: rtl/pllcfg_chan.sv
module pllcfg_chan
   import pllcfg_pkg::*;
#(
   parameter int LOCK_CYCLES = 24
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     commit,
   input  pll_cfg_t staged,
   output pll_cfg_t act,
   output logic     ready
);
   localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

   logic [CNT_W-1:0] cnt;
   logic             same_rate;
   logic             want_lock;

   assign same_rate = (staged.mul == act.mul) && (staged.frac == act.frac);
   assign want_lock = staged.pll_en && staged.lock_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act   <= '0;
         ready <= 1'b0;
         cnt   <= '0;
      end else begin
         if (commit) act <= staged;
         if (commit && !want_lock) begin
            ready <= 1'b0;
            cnt   <= '0;
         end else if (commit && !(same_rate && (ready || cnt != '0))) begin
            ready <= 1'b0;
            cnt   <= CNT_W'(LOCK_CYCLES);
         end else if (cnt == CNT_W'(1)) begin
            ready <= 1'b1;
            cnt   <= '0;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   AST_OFF_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !staged.pll_en) |=> !ready) else $error("ready kept after disable"); // R7
   AST_RATE_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && want_lock && !same_rate) |=> !ready) else $error("ready kept on new rate"); // R8
   AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && ready && want_lock && same_rate) |=> ready) else $error("locked channel dropped"); // R9
   AST_READY_NEEDS_LOCK_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (act.pll_en && act.lock_en)) else $error("ready without lock enable"); // R10
   AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act)) else $error("running config moved without commit"); // R4
endmodule

// File: rtl/pllcfg_bank.sv
module pllcfg_bank
   import pllcfg_pkg::*;
#(
   parameter int N_CH        = 8,
   parameter int LOCK_CYCLES = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               addr,
   input  logic [31:0]              wdata,
   output logic [31:0]              rdata,
   output logic [N_CH-1:0]          ready,
   output logic [N_CH*MUL_W-1:0]    act_mul,
   output logic [N_CH*FRAC_W-1:0]   act_frac,
   output logic [N_CH*DIV_W-1:0]    act_div,
   output logic [N_CH-1:0]          pll_on,
   output logic [N_CH-1:0]          div_on
);
   localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   if (N_CH < 1 || N_CH > (1 << IDX_FW)) begin : g_bad_nch
      $error("N_CH must lie in 1..16");
   end
   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("LOCK_CYCLES must be at least 1");
   end

   pll_cfg_t         staged;
   pll_cfg_t         act [N_CH];
   logic [SEL_W-1:0] sel_q;
   logic             commit;
   logic [SEL_W-1:0] commit_idx;
   pll_cfg_t         sel_cfg;

   pllcfg_stage #(.N_CH(N_CH), .SEL_W(SEL_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .staged(staged), .sel_q(sel_q), .commit(commit), .commit_idx(commit_idx)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      pllcfg_chan #(.LOCK_CYCLES(LOCK_CYCLES)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .commit(commit && (int'(commit_idx) == i)),
         .staged(staged), .act(act[i]), .ready(ready[i])
      );
      assign act_mul[i*MUL_W +: MUL_W]    = act[i].mul;
      assign act_frac[i*FRAC_W +: FRAC_W] = act[i].frac;
      assign act_div[i*DIV_W +: DIV_W]    = act[i].div;
      assign pll_on[i]                    = act[i].pll_en;
      assign div_on[i]                    = act[i].div_en;
   end

   assign sel_cfg = act[sel_q];

   always_comb begin
      rdata = '0;
      case (addr)
         REG_CTL0: begin
            rdata[DIV_W-1:0] = sel_cfg.div;
            rdata[PLLEN_B]   = sel_cfg.pll_en;
            rdata[LOCKEN_B]  = sel_cfg.lock_en;
            rdata[DIVEN_B]   = sel_cfg.div_en;
         end
         REG_CTL1: begin
            rdata[MUL_LSB +: MUL_W] = sel_cfg.mul;
            rdata[FRAC_W-1:0]       = sel_cfg.frac;
         end
         REG_UPDT: rdata[SEL_W-1:0] = sel_q;
         default:  rdata[N_CH-1:0]  = ready;
      endcase
   end

   AST_GO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == REG_UPDT) |-> !rdata[GO_B]) else $error("commit bit read back set"); // R3
   AST_STATUS_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == REG_STAT) |-> (rdata[N_CH-1:0] == ready)) else $error("status differs from ready"); // R6
endmodule

// File: tb/pllcfg_bank_bench.sv
module pllcfg_bank_bench;
   localparam int NC = 8;
   localparam int LC = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NC-1:0] ready;
   logic [NC*8-1:0] act_mul;
   logic [NC*22-1:0] act_frac;
   logic [NC*8-1:0] act_div;
   logic [NC-1:0] pll_on;
   logic [NC-1:0] div_on;

   int total = 0;
   int bad = 0;
   bit done = 0;

   pllcfg_bank #(.N_CH(NC), .LOCK_CYCLES(LC)) u_pllcfg_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .ready(ready), .act_mul(act_mul), .act_frac(act_frac),
      .act_div(act_div), .pll_on(pll_on), .div_on(div_on)
   );

   always #10 clk = ~clk;

   // reference model
   int m_mul[NC], m_frac[NC], m_div[NC], m_cnt[NC];
   bit m_pen[NC], m_len[NC], m_den[NC], m_rdy[NC];
   int s_mul, s_frac, s_div, sel;
   bit s_pen, s_len, s_den;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NC; i++) begin
            m_mul[i] = 0; m_frac[i] = 0; m_div[i] = 0; m_cnt[i] = 0;
            m_pen[i] = 0; m_len[i] = 0; m_den[i] = 0; m_rdy[i] = 0;
         end
         s_mul = 0; s_frac = 0; s_div = 0; sel = 0;
         s_pen = 0; s_len = 0; s_den = 0;
      end else begin
         int ci;
         bit go;
         ci = int'(wdata[3:0]);
         go = wr_en && addr == 2'd2 && wdata[8] && ci < NC;
         for (int i = 0; i < NC; i++) begin
            if (go && i == ci) begin
               bit same;
               same = (s_mul == m_mul[i]) && (s_frac == m_frac[i]);
               if (!(s_pen && s_len)) begin
                  m_rdy[i] = 0; m_cnt[i] = 0;
               end else if (same && (m_rdy[i] || m_cnt[i] > 0)) begin
                  if (m_cnt[i] == 1) begin m_rdy[i] = 1; m_cnt[i] = 0; end
                  else if (m_cnt[i] > 1) m_cnt[i]--;
               end else begin
                  m_rdy[i] = 0; m_cnt[i] = LC;
               end
               m_mul[i] = s_mul; m_frac[i] = s_frac; m_div[i] = s_div;
               m_pen[i] = s_pen; m_len[i] = s_len; m_den[i] = s_den;
            end else if (m_cnt[i] == 1) begin
               m_rdy[i] = 1; m_cnt[i] = 0;
            end else if (m_cnt[i] > 1) m_cnt[i]--;
         end
         if (wr_en) begin
            case (addr)
               2'd0: begin
                  s_div = int'(wdata[7:0]); s_pen = wdata[28];
                  s_len = wdata[29]; s_den = wdata[31];
               end
               2'd1: begin s_mul = int'(wdata[31:24]); s_frac = int'(wdata[21:0]); end
               2'd2: if (ci < NC) sel = ci;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [1:0] a);
      logic [31:0] r;
      r = '0;
      case (a)
         2'd0: begin
            r[7:0] = 8'(m_div[sel]); r[28] = m_pen[sel];
            r[29] = m_len[sel]; r[31] = m_den[sel];
         end
         2'd1: begin r[31:24] = 8'(m_mul[sel]); r[21:0] = 22'(m_frac[sel]); end
         2'd2: r[3:0] = 4'(sel);
         default: for (int i = 0; i < NC; i++) r[i] = m_rdy[i];
      endcase
      return r;
   endfunction

   // per-cycle comparison of ready (R6, R7, R8, R9, R10) and running fields (R4, R5)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NC-1:0] er;
         bit cfg_ok;
         cfg_ok = 1;
         for (int i = 0; i < NC; i++) begin
            er[i] = m_rdy[i];
            if (act_mul[i*8 +: 8] != 8'(m_mul[i]) || act_frac[i*22 +: 22] != 22'(m_frac[i]) ||
                act_div[i*8 +: 8] != 8'(m_div[i]) || pll_on[i] != m_pen[i] || div_on[i] != m_den[i])
               cfg_ok = 0;
         end
         total++;
         if (ready !== er) begin
            bad++;
            $display("FAIL R8 ready per-cycle at %0t: actual=%b expected=%b", $time, ready, er);
         end
         total++;
         if (!cfg_ok) begin
            bad++;
            $display("FAIL R4 running config at %0t: actual mul=%h div=%h expected ch%0d mul=%h",
                     $time, act_mul, act_div, sel, m_mul[sel]);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      addr = a;
      #1;
      total++;
      if (rdata !== e || rdata !== exp_rd(a)) begin
         bad++;
         $display("FAIL %s read addr %0d: actual=%h expected=%h", tag, a, rdata, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      // R1: reset state
      rd_chk(2'd0, 32'h0, "R1");
      rd_chk(2'd1, 32'h0, "R1");
      rd_chk(2'd2, 32'h0, "R1");
      rd_chk(2'd3, 32'h0, "R1");
      // R4/R5: stage a config, nothing visible before commit
      wr(2'd1, {8'h31, 2'b11, 22'h012345});
      wr(2'd0, 32'hB000_0003 | 32'h0000_0F00);
      rd_chk(2'd0, 32'h0, "R4");
      // commit channel 2 (R8)
      wr(2'd2, 32'h0000_0102);
      idle(10);
      rd_chk(2'd3, 32'h0, "R8");
      idle(16);
      rd_chk(2'd3, 32'h0000_0004, "R6");
      rd_chk(2'd0, 32'hB000_0003, "R5");
      rd_chk(2'd1, 32'h3101_2345, "R5");
      rd_chk(2'd2, 32'h0000_0002, "R3");
      // R9: same values again on a locked channel
      wr(2'd2, 32'h0000_0102);
      idle(3);
      rd_chk(2'd3, 32'h0000_0004, "R9");
      // R8: fraction change restarts, R9: repeat commit mid-count does not
      wr(2'd1, {8'h31, 2'b00, 22'h000777});
      wr(2'd2, 32'h0000_0102);
      idle(5);
      wr(2'd2, 32'h0000_0102);
      idle(30);
      rd_chk(2'd3, 32'h0000_0004, "R8");
      // R2: out-of-range index ignored
      wr(2'd2, 32'h0000_0109);
      rd_chk(2'd2, 32'h0000_0002, "R2");
      wr(2'd2, 32'h0000_010F);
      rd_chk(2'd3, 32'h0000_0004, "R2");
      // R3: select-only write
      wr(2'd2, 32'h0000_0000);
      rd_chk(2'd2, 32'h0, "R3");
      rd_chk(2'd0, 32'h0, "R3");
      // highest channel
      wr(2'd2, 32'h0000_0107);
      idle(30);
      rd_chk(2'd3, 32'h0000_0084, "R6");
      // R10: lock enable clear, never ready
      wr(2'd0, 32'h1000_0005);
      wr(2'd2, 32'h0000_0105);
      idle(40);
      rd_chk(2'd3, 32'h0000_0084, "R10");
      // R7: disabling drops ready at once
      wr(2'd0, 32'h0);
      wr(2'd2, 32'h0000_0102);
      rd_chk(2'd3, 32'h0000_0080, "R7");
      idle(3);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      total++;
      bad++;
      done = 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule